// File: doc/BRIEF.md
# SDRAM Bring-Up and Refresh Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM. After reset it holds the command bus idle for the power-on settling time. It then closes every bank, runs a burst of auto-refresh commands and writes the mode register, with a fixed timed gap after each step. A strap input picks which of the two legal orderings is used: refreshes first and the mode write last, or the mode write first and the refreshes after it. Every gap is a parameter in nanoseconds (or in cycles for the mode-write gap). Each one is turned into a whole number of clock cycles by rounding up.

Once bring-up is complete, the block keeps a count of refreshes that are owed. One is added per refresh interval. While anything is owed, the user-ready output stays low. When the user's scheduler reports that all banks are idle, the block takes the bus and issues a precharge-all, then an auto-refresh, once for each refresh owed. Up to a fixed limit, refreshes can be postponed while the user keeps banks open. A tick that arrives when the count is already at the limit sets a sticky overflow flag.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While reset is low, and for exactly CP cycles after reset is released, the command bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) and user_ready is low. CP is the power-on wait converted to cycles by ceil(ns*1000/period_ps), with a floor of 2. Every other gap is converted the same way with a floor of 1.
- R2: The first command, in cycle CP, is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 = 1, every other address bit 0, and bank address 0.
- R3: With refresh_first=1, INIT_REFRESHES auto-refresh commands (cs_n, ras_n, cas_n = 0, we_n=1) follow. The first comes C_RP cycles after the precharge and the rest are spaced C_RFC cycles apart. The mode write comes C_RFC cycles after the last of them.
- R4: With refresh_first=0, the mode write comes C_RP cycles after the precharge. The first auto-refresh follows C_MRD cycles after the mode write, and the rest are spaced C_RFC apart.
- R5: The mode write drives all four command lines low and bank address 0. Its address equals mode_word with bits 7, 8, 10 and 11 forced to 0, which is mode_word AND 0x27F.
- R6: init_done and user_ready rise together. In order refresh_first=1 this happens C_MRD cycles after the mode write; in order refresh_first=0 it happens C_RFC cycles after the last auto-refresh. init_done then stays high, and no command appears between the last bring-up command and that cycle.
- R7: After bring-up, one refresh is owed for every C_REFI cycles. With banks_idle high, the first precharge-all comes C_REFI+1 cycles after init_done rises, and the auto-refresh comes C_RP cycles after it. Later pairs repeat every C_REFI cycles.
- R8: user_ready is low from the cycle after a refresh becomes owed until C_RFC cycles after the auto-refresh that clears the debt. While user_ready is high, the command bus is NOP.
- R9: While banks_idle is low, no command is issued and owed refreshes accumulate. When banks_idle rises, the block issues one precharge-all/auto-refresh pair per refresh owed. The precharge follows in the next cycle, and each pair starts C_RP+C_RFC+1 cycles after the one before it.
- R10: A refresh tick that arrives with DEBT_LIMIT refreshes already owed sets refresh_overflow in the following cycle. Reaching exactly DEBT_LIMIT does not set it. Once set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_first | input | 1 | Bring-up order: 1 = refreshes before the mode write, 0 = mode write first |
| mode_word | input | ADDR_W | Value for the mode write; the forbidden bits are cleared |
| banks_idle | input | 1 | The user scheduler reports that all banks are closed |
| user_ready | output | 1 | The user may issue commands |
| init_done | output | 1 | Bring-up has finished |
| refresh_overflow | output | 1 | Sticky flag: the refresh debt exceeded its limit |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |

## Verification
Every internal error in this block shows up on the command bus as a command in the wrong cycle. A wrong gap-timer load or a wrong return state moves every later command in bring-up by a fixed number of cycles, so the first misplaced precharge, refresh or mode write exposes it. A fault in the refresh debt shows within one refresh interval after bring-up: the number of precharge/refresh pairs differs from the number of ticks, or user_ready is in the wrong phase. An off-by-one in the overflow comparison changes the single cycle in which refresh_overflow rises.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWR, ST_PREA, ST_IREF, ST_MRS, ST_WAIT, ST_RUN, ST_RPRE, ST_RREF
    } seq_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Convert a time in ns to whole clock cycles (rounded up), never below lo.
    function automatic int ns_to_cycles(int ns_val, int clk_ps, int lo);
        int c;
        c = (ns_val * 1000 + clk_ps - 1) / clk_ps;
        return (c < lo) ? lo : c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
        last = (cnt_q <= CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RST_VAL);
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sdr_refresh_debt.sv
module sdr_refresh_debt #(
    parameter int PERIOD_C = 1560,
    parameter int LIMIT    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic issued,
    output logic pending,
    output logic overflow
);
    localparam int PW = $clog2(PERIOD_C + 1);
    localparam int DW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [PW-1:0] per;
        logic [DW-1:0] debt;
        logic          ovf;
    } debt_t;

    debt_t d, q;
    logic  tick;

    always_comb begin
        d    = q;
        tick = run && (q.per == PW'(PERIOD_C - 1));
        if (!run)
            d.per = '0;
        else if (tick)
            d.per = '0;
        else
            d.per = q.per + 1'b1;

        case ({tick, issued})
            2'b10: begin
                if (q.debt == DW'(LIMIT))
                    d.ovf = 1'b1;
                else
                    d.debt = q.debt + 1'b1;
            end
            2'b01: if (q.debt != '0) d.debt = q.debt - 1'b1;
            default: d.debt = q.debt;
        endcase
        pending  = (q.debt != '0);
        overflow = q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf);

    a_r9_debt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.debt <= DW'(LIMIT));

    a_r9_issue_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
        issued |-> q.debt != '0);

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
    import sdr_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS       = 10000,
    parameter int POWER_WAIT_NS       = 200000,
    parameter int PRECHARGE_NS        = 20,
    parameter int REFRESH_CYCLE_NS    = 70,
    parameter int MRS_GAP_CYC         = 2,
    parameter int REFRESH_INTERVAL_NS = 15600,
    parameter int INIT_REFRESHES      = 8,
    parameter int DEBT_LIMIT          = 8,
    parameter int ADDR_W              = 12,
    parameter int BA_W                = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_first,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              banks_idle,
    output logic              user_ready,
    output logic              init_done,
    output logic              refresh_overflow,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);
    localparam int C_POWER = ns_to_cycles(POWER_WAIT_NS, CLK_PERIOD_PS, 2);
    localparam int C_RP    = ns_to_cycles(PRECHARGE_NS, CLK_PERIOD_PS, 1);
    localparam int C_RFC   = ns_to_cycles(REFRESH_CYCLE_NS, CLK_PERIOD_PS, 1);
    localparam int C_MRD   = (MRS_GAP_CYC < 1) ? 1 : MRS_GAP_CYC;
    localparam int C_REFI  = ns_to_cycles(REFRESH_INTERVAL_NS, CLK_PERIOD_PS, 2);
    localparam int C_MAX   = max2(max2(C_POWER, C_RP), max2(C_RFC, C_MRD));
    localparam int CW      = $clog2(C_MAX + 1);
    localparam int RW      = $clog2(INIT_REFRESHES + 1);
    localparam logic [ADDR_W-1:0] MRS_KEEP = ADDR_W'(10'h27F);

    typedef struct packed {
        seq_st_e       st;
        seq_st_e       after;
        logic [RW-1:0] nref;
        logic          done;
    } seq_t;

    seq_t              d, q;
    sd_cmd_t           cmd;
    logic [ADDR_W-1:0] addr;
    logic              tmr_load, tmr_last, issue_ref, pending;
    logic [CW-1:0]     tmr_val;
    logic              go;
    int                gap;
    seq_st_e           nxt;

    sdr_gap_timer #(.CNT_W(CW), .RST_VAL(C_POWER)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    sdr_refresh_debt #(.PERIOD_C(C_REFI), .LIMIT(DEBT_LIMIT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.done),
        .issued  (issue_ref),
        .pending (pending),
        .overflow(refresh_overflow)
    );

    always_comb begin
        d         = q;
        cmd       = CMD_NOP;
        addr      = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        issue_ref = 1'b0;
        go        = 1'b0;
        gap       = 1;
        nxt       = ST_RUN;
        case (q.st)
            ST_PWR:  if (tmr_last) d.st = ST_PREA;
            ST_PREA, ST_RPRE: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
                go       = 1'b1;
                gap      = C_RP;
                if (q.st == ST_RPRE)
                    nxt = ST_RREF;
                else
                    nxt = refresh_first ? ST_IREF : ST_MRS;
            end
            ST_IREF: begin
                cmd    = CMD_REF;
                go     = 1'b1;
                gap    = C_RFC;
                d.nref = q.nref + 1'b1;
                if (q.nref == RW'(INIT_REFRESHES - 1))
                    nxt = refresh_first ? ST_MRS : ST_RUN;
                else
                    nxt = ST_IREF;
            end
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_word & MRS_KEEP;
                go   = 1'b1;
                gap  = C_MRD;
                nxt  = refresh_first ? ST_RUN : ST_IREF;
            end
            ST_RREF: begin
                cmd       = CMD_REF;
                issue_ref = 1'b1;
                go        = 1'b1;
                gap       = C_RFC;
                nxt       = ST_RUN;
            end
            ST_WAIT: if (tmr_last) d.st = q.after;
            ST_RUN:  if (pending && banks_idle) d.st = ST_RPRE;
            default: d.st = ST_PWR;
        endcase
        if (go) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(gap - 1);
            d.after  = nxt;
            d.st     = (gap <= 1) ? nxt : ST_WAIT;
        end
        if (d.st == ST_RUN)
            d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_PWR;
            q.after <= ST_PWR;
            q.nref  <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sd_cs_n    = cmd.cs_n;
    assign sd_ras_n   = cmd.ras_n;
    assign sd_cas_n   = cmd.cas_n;
    assign sd_we_n    = cmd.we_n;
    assign sd_addr    = addr;
    assign sd_ba      = '0;
    assign init_done  = q.done;
    assign user_ready = (q.st == ST_RUN) && !pending;

    a_r2_prea_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> (sd_addr[10] && sd_ba == '0));

    a_r5_mrs_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
            |-> (!sd_addr[7] && !sd_addr[8] && !sd_addr[10] && !sd_addr[11] && sd_ba == '0));

    a_r8_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        user_ready |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        user_ready |-> init_done);

endmodule

// File: tb/sim_sdr_bringup_seq.sv
module sim_sdr_bringup_seq;
    localparam int PER_PS  = 10000;
    localparam int POW_NS  = 200;
    localparam int RP_NS   = 15;
    localparam int RFC_NS  = 65;
    localparam int MRD_C   = 2;
    localparam int REFI_NS = 400;
    localparam int NREF    = 8;
    localparam int MAXD    = 8;
    localparam int AW      = 12;

    function automatic int to_cyc(int ns, int lo);
        int c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < lo) ? lo : c;
    endfunction

    localparam int CP    = to_cyc(POW_NS, 2);
    localparam int CRP   = to_cyc(RP_NS, 1);
    localparam int CRFC  = to_cyc(RFC_NS, 1);
    localparam int CMRD  = MRD_C;
    localparam int CREFI = to_cyc(REFI_NS, 2);
    localparam int TRUN  = CP + CRP + CMRD + NREF * CRFC;
    localparam int NB    = NREF + 2;
    localparam int TRN   = 1024;

    localparam int K_NOP = 7;
    localparam int K_PRE = 2;
    localparam int K_REF = 1;
    localparam int K_MRS = 0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_first = 1'b1;
    logic [AW-1:0] mode_word = '0;
    logic          banks_idle = 1'b1;
    logic          user_ready, init_done, refresh_overflow;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;
    logic [1:0]    sd_ba;

    always #5 clk = ~clk;

    sdr_bringup_seq #(
        .CLK_PERIOD_PS(PER_PS), .POWER_WAIT_NS(POW_NS), .PRECHARGE_NS(RP_NS),
        .REFRESH_CYCLE_NS(RFC_NS), .MRS_GAP_CYC(MRD_C), .REFRESH_INTERVAL_NS(REFI_NS),
        .INIT_REFRESHES(NREF), .DEBT_LIMIT(MAXD), .ADDR_W(AW), .BA_W(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .refresh_first(refresh_first), .mode_word(mode_word),
        .banks_idle(banks_idle), .user_ready(user_ready), .init_done(init_done),
        .refresh_overflow(refresh_overflow), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int n_log   = 0;
    int lg_cmd  [0:63];
    int lg_idx  [0:63];
    int lg_addr [0:63];
    int lg_ba   [0:63];
    bit rdy_tr  [0:TRN-1];
    bit done_tr [0:TRN-1];
    bit err_tr  [0:TRN-1];
    bit finished = 1'b0;

    // Command monitor: samples at the falling edge, one entry per non-NOP cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc   = 0;
            n_log = 0;
        end else begin
            if (cyc < TRN) begin
                rdy_tr[cyc]  = user_ready;
                done_tr[cyc] = init_done;
                err_tr[cyc]  = refresh_overflow;
            end
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111 && n_log < 64) begin
                lg_cmd[n_log]  = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
                lg_idx[n_log]  = cyc;
                lg_addr[n_log] = int'(sd_addr);
                lg_ba[n_log]   = int'(sd_ba);
                n_log = n_log + 1;
            end
            cyc = cyc + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start(input bit ord, input logic [AW-1:0] mw, input bit idl);
        rst_n = 1'b0;
        refresh_first = ord;
        mode_word = mw;
        banks_idle = idl;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset bus NOP", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), K_NOP);
        chk("R1 reset user_ready low", int'(user_ready), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_cmd(input string tag, input int k, input int code, input int idx);
        chk({tag, " cmd"}, lg_cmd[k], code);
        chk({tag, " cycle"}, lg_idx[k], idx);
    endtask

    task automatic check_init(input bit ord, input logic [AW-1:0] mw);
        int mexp;
        int hi;
        mexp = int'(mw & 12'h27F);
        expect_cmd("R1 R2 first precharge", 0, K_PRE, CP);
        chk("R2 precharge addr", lg_addr[0], 12'h400);
        chk("R2 precharge bank", lg_ba[0], 0);
        if (ord) begin
            for (int i = 0; i < NREF; i++)
                expect_cmd("R3 init refresh", 1 + i, K_REF, CP + CRP + i * CRFC);
            expect_cmd("R3 mode write after refreshes", NREF + 1, K_MRS, CP + CRP + NREF * CRFC);
            chk("R5 mode addr", lg_addr[NREF + 1], mexp);
            chk("R5 mode bank", lg_ba[NREF + 1], 0);
        end else begin
            expect_cmd("R4 mode write first", 1, K_MRS, CP + CRP);
            chk("R5 mode addr", lg_addr[1], mexp);
            chk("R5 mode bank", lg_ba[1], 0);
            for (int i = 0; i < NREF; i++)
                expect_cmd("R4 init refresh", 2 + i, K_REF, CP + CRP + CMRD + i * CRFC);
        end
        chk("R6 no extra commands", n_log, NB);
        chk("R6 init_done before", int'(done_tr[TRUN - 1]), 0);
        chk("R6 init_done rises", int'(done_tr[TRUN]), 1);
        chk("R6 user_ready rises", int'(rdy_tr[TRUN]), 1);
        hi = 0;
        for (int c = 0; c < TRUN; c++) hi += int'(rdy_tr[c]);
        chk("R1 user_ready low during bring-up", hi, 0);
    endtask

    function automatic logic [AW-1:0] pat(input int m);
        case (m)
            0: return 12'hFFF;
            1: return 12'h000;
            2: return 12'hD80;
            default: return 12'h2A5;
        endcase
    endfunction

    initial begin
        // Both orders across several mode words.
        for (int o = 0; o < 2; o++) begin
            for (int m = 0; m < 4; m++) begin
                start(o[0], pat(m), 1'b1);
                wait_to(TRUN + 5);
                check_init(o[0], pat(m));
            end
        end

        // R7 / R8: periodic refresh with banks idle.
        start(1'b1, 12'h033, 1'b1);
        wait_to(TRUN + 2 * CREFI + 10);
        expect_cmd("R7 refresh precharge", NB, K_PRE, TRUN + CREFI + 1);
        chk("R7 refresh precharge addr", lg_addr[NB], 12'h400);
        expect_cmd("R7 refresh", NB + 1, K_REF, TRUN + CREFI + 1 + CRP);
        expect_cmd("R7 second precharge", NB + 2, K_PRE, TRUN + 2 * CREFI + 1);
        expect_cmd("R7 second refresh", NB + 3, K_REF, TRUN + 2 * CREFI + 1 + CRP);
        chk("R8 ready before tick", int'(rdy_tr[TRUN + CREFI - 1]), 1);
        chk("R8 ready drops when owed", int'(rdy_tr[TRUN + CREFI]), 0);
        chk("R8 ready low in recovery", int'(rdy_tr[TRUN + CREFI + CRP + CRFC]), 0);
        chk("R8 ready back", int'(rdy_tr[TRUN + CREFI + 1 + CRP + CRFC]), 1);

        // R9: postponed refreshes, then serviced back to back.
        start(1'b1, 12'h033, 1'b0);
        wait_to(TRUN + 3 * CREFI + 2);
        chk("R9 nothing issued while busy", n_log, NB);
        banks_idle = 1'b1;
        wait_to(TRUN + 4 * CREFI + 10);
        for (int p = 0; p < 3; p++) begin
            expect_cmd("R9 owed precharge", NB + 2 * p, K_PRE,
                       TRUN + 3 * CREFI + 3 + p * (CRP + CRFC + 1));
            expect_cmd("R9 owed refresh", NB + 2 * p + 1, K_REF,
                       TRUN + 3 * CREFI + 3 + CRP + p * (CRP + CRFC + 1));
        end
        expect_cmd("R9 next regular precharge", NB + 6, K_PRE, TRUN + 4 * CREFI + 1);
        chk("R9 ready after debt cleared", int'(rdy_tr[TRUN + 3 * CREFI + 3 + 3 * (CRP + CRFC + 1) - 1]), 1);
        chk("R9 no overflow", int'(err_tr[TRUN + 4 * CREFI]), 0);

        // R10: debt overflow while banks stay busy.
        start(1'b1, 12'h033, 1'b0);
        wait_to(TRUN + (MAXD + 1) * CREFI + 20);
        chk("R10 no flag at limit", int'(err_tr[TRUN + MAXD * CREFI + 5]), 0);
        chk("R10 no flag before tick", int'(err_tr[TRUN + (MAXD + 1) * CREFI - 1]), 0);
        chk("R10 flag after overflow tick", int'(err_tr[TRUN + (MAXD + 1) * CREFI]), 1);
        chk("R10 flag sticky", int'(err_tr[TRUN + (MAXD + 1) * CREFI + 15]), 1);
        chk("R10 R9 no commands while busy", n_log, NB);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule